// File: doc/BRIEF.md
# Indirectly Programmed Address Region Decoder

This block keeps a table of 20 physical-memory regions and classifies addresses against it. Software never writes a table entry directly. It loads one 64-bit staging register with an entry index, an inclusive upper limit and a set of attribute bits. It then raises a commit bit in that same register, and the staged fields are copied into the selected entry as one write. The commit bit clears itself one cycle later. The staging register can be read back.

The regions are ordered. Each entry stores only its inclusive upper limit, at 64 MB granularity on address bits 51:26. The lower bound of each entry is the limit of the entry below it. An address lookup is purely combinational. It returns a hit flag, the index of the matching entry and that entry's attribute bits. If the table was programmed badly and more than one entry matches, the lowest index is returned. A separate flag reports when the programmed table breaks the ordering rules.

Top module: `region_map_decoder`

## Requirements
- R1: After reset the staging register reads 0, no entry is valid, every entry's limit is all ones and every other entry field is 0. A lookup then misses.
- R2: An entry is written only in the cycle after the commit bit (staging bit 6) goes from 0 to 1. The index, limit, attributes and valid bit are all taken from the staging register in that single write. A staging write with bit 6 at 0 leaves the table unchanged. A second write that keeps bit 6 at 1 also leaves the table unchanged.
- R3: Staging bit 6 reads 1 in the cycle after it was written as 1, and reads 0 one cycle later unless it is written again.
- R4: A commit whose index field (staging bits 4:0) is 20 to 31 leaves all 20 entries unchanged.
- R5: Entry 0 hits when it is valid and address bits 51:26 are less than or equal to its limit. The limit is inclusive.
- R6: Entry N, for N > 0, hits only when address bits 51:26 are also strictly greater than the limit of entry N-1.
- R7: When several entries hit, the lowest index is reported.
- R8: On a miss, the hit flag, the index and all attribute bits are 0.
- R9: Staging field positions are: limit in 51:26, valid in 7, sub-entry id in 11:8, and attribute flags in 24:15. The flags are dedup (24), low bandwidth (23), forced non-posted write (22), secondary first (21), mirror (20), near-memory cacheable (19), DDR4 (18), block (17), persistent (16) and non-persistent far memory (15). The attribute output carries bits 24:15 in its bits 13:4 and the sub-entry id in its bits 3:0.
- R10: Readback returns the staging register with bits 63:52, 25, 14:12 and 5 always 0.
- R11: The error flag is 1 exactly when some entry N > 0 is valid and either entry N-1 is invalid or its limit is not strictly above the limit of entry N-1.
- R12: An invalid entry never hits, even when the address lies inside its range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Staging register write strobe |
| cfg_wdata_i | input | 64 | Staging register write data |
| cfg_rdata_o | output | 64 | Staging register readback |
| lkp_addr_i | input | 52 | Physical address to classify |
| lkp_hit_o | output | 1 | An entry matched |
| lkp_idx_o | output | 5 | Index of the matching entry |
| lkp_attr_o | output | 14 | Attributes of the matching entry |
| cfg_err_o | output | 1 | Table violates the ordering rules |

## Verification
The hardest case to reach is an overlap, where two entries match the same address. A correctly programmed table cannot produce one. The bench reaches it on purpose by committing an entry whose limit lies below the limit of the entry before it. The next entry's lower bound then drops, and its range covers addresses that lower entries also claim, so lowest-index priority and the error flag can both be observed. The rising-edge rule for the commit bit is tested with two back-to-back staging writes that both carry bit 6 set; the second of them must not commit. A gap in the valid chain shows both the reset limit value and the rule that an invalid entry never matches.

// File: rtl/region_map_pkg.sv
package region_map_pkg;
  localparam int ADDR_W  = 52;
  localparam int LIM_LSB = 26;
  localparam int LIM_W   = ADDR_W - LIM_LSB;
  localparam int FLAG_W  = 10;
  localparam int SUB_W   = 4;
  localparam int ATTR_W  = FLAG_W + SUB_W;
  localparam int STG_W   = 64;

  // staging field positions
  localparam int POS_IDX = 0;
  localparam int POS_WEN = 6;
  localparam int POS_VLD = 7;
  localparam int POS_SUB = 8;
  localparam int POS_FLG = 15;
  localparam int POS_LIM = LIM_LSB;

  typedef struct packed {
    logic              vld;
    logic [LIM_W-1:0]  lim;
    logic [FLAG_W-1:0] flg;
    logic [SUB_W-1:0]  sub;
  } rgn_ent_t;

  function automatic logic [STG_W-1:0] stg_mask(input int idx_w);
    logic [STG_W-1:0] m;
    m = '0;
    for (int b = 0; b < STG_W; b++) begin
      if ((b >= POS_IDX && b < POS_IDX + idx_w) ||
          (b >= POS_WEN && b < POS_SUB + SUB_W) ||
          (b >= POS_FLG && b < POS_FLG + FLAG_W) ||
          (b >= POS_LIM && b < POS_LIM + LIM_W))
        m[b] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/rgn_stage.sv
module rgn_stage
  import region_map_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [STG_W-1:0] wdata_i,
  output logic [STG_W-1:0] rdata_o,
  output logic             commit_o,
  output logic [IDX_W-1:0] idx_o,
  output rgn_ent_t         ent_o
);
  localparam logic [STG_W-1:0] MASK = stg_mask(IDX_W);

  logic [STG_W-1:0] stg_q;
  logic             wen_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q   <= '0;
      wen_d_q <= 1'b0;
    end else begin
      wen_d_q <= stg_q[POS_WEN];
      if (we_i) stg_q <= wdata_i & MASK;
      else      stg_q[POS_WEN] <= 1'b0;
    end
  end

  assign commit_o  = stg_q[POS_WEN] & ~wen_d_q;
  assign rdata_o   = stg_q;
  assign idx_o     = stg_q[POS_IDX +: IDX_W];
  assign ent_o.vld = stg_q[POS_VLD];
  assign ent_o.lim = stg_q[POS_LIM +: LIM_W];
  assign ent_o.flg = stg_q[POS_FLG +: FLAG_W];
  assign ent_o.sub = stg_q[POS_SUB +: SUB_W];

  p_wen_self_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stg_q[POS_WEN] && !we_i) |=> !stg_q[POS_WEN]);
  p_commit_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);
  p_commit_needs_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> !commit_o);
  p_reserved_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~MASK) == '0);
endmodule

// File: rtl/rgn_table.sv
module rgn_table
  import region_map_pkg::*;
#(
  parameter int N_ENT = 20,
  parameter int IDX_W = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 commit_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  rgn_ent_t             ent_i,
  output rgn_ent_t [N_ENT-1:0] tbl_o
);
  rgn_ent_t [N_ENT-1:0] tbl_q;
  logic     [N_ENT-1:0] sel;

  for (genvar n = 0; n < N_ENT; n++) begin : g_sel
    assign sel[n] = commit_i && (idx_i == IDX_W'(n));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < N_ENT; n++) begin
        tbl_q[n].vld <= 1'b0;
        tbl_q[n].lim <= '1;
        tbl_q[n].flg <= '0;
        tbl_q[n].sub <= '0;
      end
    end else begin
      for (int n = 0; n < N_ENT; n++)
        if (sel[n]) tbl_q[n] <= ent_i;
    end
  end

  assign tbl_o = tbl_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(tbl_q));
  p_oob_ignore_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && idx_i >= IDX_W'(N_ENT)) |=> $stable(tbl_q));
  p_sel_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));
endmodule

// File: rtl/rgn_match.sv
module rgn_match
  import region_map_pkg::*;
#(
  parameter int N_ENT = 20,
  parameter int IDX_W = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  rgn_ent_t [N_ENT-1:0] tbl_i,
  output logic                 hit_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic [ATTR_W-1:0]    attr_o,
  output logic                 cfg_err_o
);
  logic [LIM_W-1:0] a_lim;
  logic [N_ENT-1:0] hit_vec;
  logic [N_ENT-1:0] err_vec;

  assign a_lim = addr_i[ADDR_W-1:LIM_LSB];

  for (genvar n = 0; n < N_ENT; n++) begin : g_cmp
    if (n == 0) begin : g_first
      assign hit_vec[n] = tbl_i[n].vld && (a_lim <= tbl_i[n].lim);
      assign err_vec[n] = 1'b0;
    end else begin : g_rest
      assign hit_vec[n] = tbl_i[n].vld && (a_lim <= tbl_i[n].lim) &&
                          (a_lim > tbl_i[n-1].lim);
      assign err_vec[n] = tbl_i[n].vld &&
                          (!tbl_i[n-1].vld || (tbl_i[n].lim <= tbl_i[n-1].lim));
    end
  end

  // lowest index wins
  always_comb begin
    hit_o  = 1'b0;
    idx_o  = '0;
    attr_o = '0;
    for (int n = N_ENT - 1; n >= 0; n--) begin
      if (hit_vec[n]) begin
        hit_o  = 1'b1;
        idx_o  = IDX_W'(n);
        attr_o = {tbl_i[n].flg, tbl_i[n].sub};
      end
    end
  end

  assign cfg_err_o = |err_vec;

  p_miss_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (idx_o == '0 && attr_o == '0));
  p_hit_valid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> tbl_i[idx_o].vld);
  p_hit_upper_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (a_lim <= tbl_i[idx_o].lim));
  p_hit_lower_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && idx_o != '0) |-> (a_lim > tbl_i[idx_o - 1'b1].lim));
endmodule

// File: rtl/region_map_decoder.sv
module region_map_decoder
  import region_map_pkg::*;
#(
  parameter int N_ENT = 20,
  parameter int IDX_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [STG_W-1:0]  cfg_wdata_i,
  output logic [STG_W-1:0]  cfg_rdata_o,
  input  logic [ADDR_W-1:0] lkp_addr_i,
  output logic              lkp_hit_o,
  output logic [IDX_W-1:0]  lkp_idx_o,
  output logic [ATTR_W-1:0] lkp_attr_o,
  output logic              cfg_err_o
);
  logic                 commit;
  logic [IDX_W-1:0]     stg_idx;
  rgn_ent_t             stg_ent;
  rgn_ent_t [N_ENT-1:0] tbl;

  rgn_stage #(.IDX_W(IDX_W)) u_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .rdata_o  (cfg_rdata_o),
    .commit_o (commit),
    .idx_o    (stg_idx),
    .ent_o    (stg_ent)
  );

  rgn_table #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .idx_i    (stg_idx),
    .ent_i    (stg_ent),
    .tbl_o    (tbl)
  );

  rgn_match #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_match (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (lkp_addr_i),
    .tbl_i     (tbl),
    .hit_o     (lkp_hit_o),
    .idx_o     (lkp_idx_o),
    .attr_o    (lkp_attr_o),
    .cfg_err_o (cfg_err_o)
  );
endmodule

// File: tb/region_map_decoder_tb_top.sv
module region_map_decoder_tb_top;
  localparam logic [63:0] MASK = 64'h000F_FFFF_FDFF_8FDF;
  localparam int NE = 20;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we = 1'b0;
  logic [63:0] wdata = '0;
  logic [51:0] addr = '0;
  logic [63:0] rdata;
  logic        hit;
  logic [4:0]  idx;
  logic [13:0] attr;
  logic        err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  region_map_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .lkp_addr_i(addr), .lkp_hit_o(hit),
    .lkp_idx_o(idx), .lkp_attr_o(attr), .cfg_err_o(err)
  );

  // behavioural reference
  logic [63:0] m_stg;
  bit          m_prev;
  int unsigned m_lim [NE];
  bit          m_vld [NE];
  logic [13:0] m_att [NE];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_stg = '0; m_prev = 0;
      foreach (m_lim[i]) begin m_lim[i] = 26'h3FF_FFFF; m_vld[i] = 0; m_att[i] = '0; end
    end else begin
      if (m_stg[6] && !m_prev && m_stg[4:0] < NE) begin
        m_lim[m_stg[4:0]] = m_stg[51:26];
        m_vld[m_stg[4:0]] = m_stg[7];
        m_att[m_stg[4:0]] = {m_stg[24:15], m_stg[11:8]};
      end
      m_prev = m_stg[6];
      if (we) m_stg = wdata & MASK;
      else    m_stg[6] = 1'b0;
    end
  end

  function automatic logic [20:0] m_look(input logic [51:0] a);
    int unsigned u = a[51:26];
    for (int n = 0; n < NE; n++)
      if (m_vld[n] && u <= m_lim[n] && (n == 0 || u > m_lim[n-1]))
        return {1'b1, 5'(n), m_att[n], 1'b0};
    return '0;
  endfunction

  function automatic bit m_err();
    for (int n = 1; n < NE; n++)
      if (m_vld[n] && (!m_vld[n-1] || m_lim[n] <= m_lim[n-1])) return 1;
    return 0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #3;
    if (rst_ni) begin
      logic [20:0] e;
      e = m_look(addr);
      chk("R10 model rdata", rdata, m_stg);
      chk("R5/R6/R7/R8 model lookup", {43'b0, hit, idx, attr, 1'b0}, {43'b0, e});
      chk("R11 model err", {63'b0, err}, {63'b0, m_err()});
    end
  end

  function automatic logic [63:0] mk(input int id, input int lim, input logic [9:0] flg,
                                     input logic [3:0] sub, input bit v, input bit wen);
    logic [63:0] d = '0;
    d[4:0] = 5'(id); d[6] = wen; d[7] = v; d[11:8] = sub;
    d[24:15] = flg; d[51:26] = 26'(lim);
    return d;
  endfunction

  task automatic wr(input logic [63:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic put(input int id, input int lim, input logic [9:0] flg,
                     input logic [3:0] sub, input bit v);
    wr(mk(id, lim, flg, sub, v, 1'b1));
    @(negedge clk);
  endtask

  task automatic look(input int u);
    addr = {26'(u), 26'h155_5555};
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    look(0);
    chk("R1 rdata", rdata, 64'h0);
    chk("R1 hit", {63'b0, hit}, 64'h0);
    chk("R1 err", {63'b0, err}, 64'h0);

    // R10: reserved bits read zero
    wr(~64'h40);
    #1 chk("R10 readback mask", rdata, MASK & ~64'h40);

    // R2: staged but not committed
    wr(mk(0, 5, 10'h299, 4'hA, 1, 0));
    repeat (3) @(negedge clk);
    look(0);
    chk("R2 no commit without wen", {63'b0, hit}, 64'h0);

    // R3 + R2 commit
    wr(mk(0, 5, 10'h299, 4'hA, 1, 1));
    #1 chk("R3 wen reads 1", {63'b0, rdata[6]}, 64'h1);
    @(negedge clk);
    #1 chk("R3 wen cleared", {63'b0, rdata[6]}, 64'h0);
    look(5);
    chk("R5 inclusive limit hit", {59'b0, hit, idx}, {59'b0, 1'b1, 5'd0});
    chk("R9 attributes", {50'b0, attr}, {50'b0, 10'h299, 4'hA});
    look(6);
    chk("R8 miss hit", {63'b0, hit}, 64'h0);
    chk("R8 miss outs", {45'b0, idx, attr}, 64'h0);

    // R2 rising edge: second write holding wen must not commit
    @(negedge clk); we = 1'b1; wdata = mk(1, 10, 10'h001, 4'h1, 1, 1);
    @(negedge clk); wdata = mk(2, 20, 10'h002, 4'h2, 1, 1);
    @(negedge clk); we = 1'b0;
    repeat (2) @(negedge clk);
    look(15);
    chk("R2 held wen no commit", {63'b0, hit}, 64'h0);
    look(6);
    chk("R6 lower bound exclusive", {59'b0, hit, idx}, {59'b0, 1'b1, 5'd1});
    look(10);
    chk("R6 entry1 upper", {59'b0, hit, idx}, {59'b0, 1'b1, 5'd1});

    // R4: out-of-range index ignored
    put(22, 40, 10'h3FF, 4'hF, 1);
    look(30);
    chk("R4 idx22 ignored", {63'b0, hit}, 64'h0);
    put(31, 60, 10'h3FF, 4'hF, 1);
    look(12);
    chk("R4 idx31 ignored", {63'b0, hit}, 64'h0);
    chk("R4 err unchanged", {63'b0, err}, 64'h0);

    // R7/R11: bad limit creates overlap
    put(2, 3, 10'h004, 4'h3, 1);
    put(3, 30, 10'h008, 4'h4, 1);
    chk("R11 non-increasing limit", {63'b0, err}, 64'h1);
    look(5);
    chk("R7 lowest index wins 0", {59'b0, hit, idx}, {59'b0, 1'b1, 5'd0});
    look(8);
    chk("R7 lowest index wins 1", {59'b0, hit, idx}, {59'b0, 1'b1, 5'd1});
    look(25);
    chk("R7 only entry3", {59'b0, hit, idx}, {59'b0, 1'b1, 5'd3});

    // fix, then R11 gap in valid chain, R12/R1 reset limit
    put(2, 20, 10'h004, 4'h3, 1);
    chk("R11 clean table", {63'b0, err}, 64'h0);
    put(5, 50, 10'h010, 4'h5, 1);
    chk("R11 valid after invalid", {63'b0, err}, 64'h1);
    look(40);
    chk("R12 invalid entry4 no hit, R1 reset limit bounds entry5", {63'b0, hit}, 64'h0);
    put(3, 30, 10'h008, 4'h4, 0);
    look(25);
    chk("R12 invalidated entry3", {63'b0, hit}, 64'h0);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule